// File: doc/BRIEF.md
# Match-Compare Event Timer with Dual-Clock Register Bus

This block is a 32-bit event timer for a chip's timer subsystem. A counter runs in its own slow timer clock domain. A register bus in a separate bus clock domain programs a match value, a run/auto-reset control, a prescale divider, and a write-triggered counter clear. When the counter steps onto the programmed match value, the block raises a one-cycle interrupt request in the bus domain. If auto-reset is enabled, the counter then returns to zero on the next tick, so it produces periodic events.

Every crossing between the two clocks is explicit. Control bits pass through a multi-flop synchronizer. A clear request and the match events travel as toggles. The live count reaches the bus through a four-phase-free toggle handshake that captures a snapshot, so a bus read always returns a value the counter really held. While a clear request is in flight, a status bit stays at one. Software can poll this bit before it re-arms the timer.

The bus is a simple single-cycle interface. A write takes effect at the bus clock edge on which `bus_wr` is high. Read data is a combinational function of `bus_addr`. Registers are word-aligned: match at 0x00, count at 0x04, control at 0x08, clear at 0x0C, divider at 0x10 and status at 0x14.

Top module: `tmr_match_timer`

## Requirements
- R1: After reset, every register reads 0 (match, count, control, divider, status) and `irq` is 0.
- R2: The match value (0x00) reads back as written. Control (0x08) keeps only bits [1:0], and divider (0x10) keeps only bits [1:0]; all other bits read 0. Writes to count (0x04) and status (0x14) change nothing.
- R3: While control bit 0 is 1, the counter steps up by one on each prescaled tick. A read of 0x04 returns a coherent snapshot of that count.
- R4: Clearing control bit 0 freezes the counter at its current value without zeroing it. Repeated reads then return the same value.
- R5: A divider code n (0 to 3) makes one counter tick per n+1 timer clock cycles; the reset code 0 gives divide-by-1.
- R6: Any write to 0x0C, whatever its data, zeroes the counter and its prescaler. This works while counting is disabled, and it leaves the match, control and divider registers unchanged.
- R7: Status bit 10 reads 1 from the bus cycle after a clear write until the timer domain has acknowledged that clear, and reads 0 afterwards.
- R8: Each time the counter advances onto the match value, `irq` pulses high for exactly one bus clock cycle. It never pulses if the match value is not reached.
- R9: With control bit 1 set, the tick after the count equals the match value returns the counter to 0, which gives one event every match+1 ticks. With bit 1 clear, the counter passes the match value and keeps counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register bus clock |
| tmr_clk | input | 1 | Timer (counting) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe, sampled on `bus_clk` |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | One-cycle match event pulse in the bus domain |

## Verification
The bench runs the counter for a fixed number of timer cycles under each divider code and compares the frozen count with the expected tick count. A prescaler off by one, or a divider that ignores its code, lands several counts away from that value. A clear is issued while the counter is stopped at a nonzero value. A design that gated the clear with the run bit would still show the old count, and one without the pending flag would read status 0 straight after the write. Match events are counted over a window with auto-reset both on and off. A missing auto-reset gives one event instead of about ten. A level-type interrupt shows a pulse wider than one cycle, and a counter that stopped at the match value reads far below the expected count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Register byte offsets (software decodes these)
   localparam logic [4:0] ADR_MATCH  = 5'h00;
   localparam logic [4:0] ADR_COUNT  = 5'h04;
   localparam logic [4:0] ADR_CTRL   = 5'h08;
   localparam logic [4:0] ADR_CLEAR  = 5'h0C;
   localparam logic [4:0] ADR_DIV    = 5'h10;
   localparam logic [4:0] ADR_STATUS = 5'h14;

   // Status bit reporting an in-flight clear
   localparam int STATUS_PEND_BIT = 10;

   // Control register fields: bit 0 run, bit 1 auto-reset on match
   typedef struct packed {
      logic autoclr;
      logic run;
   } ctrl_t;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("tmr_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
   import tmr_pkg::*;
#(
   parameter int CNT_W        = 32,
   parameter int DIV_W        = 2,
   parameter int SYNC_STAGES  = 2,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic             tclk,
   input  logic             rst_n,
   input  ctrl_t            ctrl_i,      // bus domain, synchronized here
   input  logic [DIV_W-1:0] div_i,       // quasi-static
   input  logic [CNT_W-1:0] match_i,     // quasi-static
   input  logic             clr_tgl_i,   // bus domain toggle
   output logic             clr_ack_o,
   input  logic             snap_req_i,  // bus domain toggle
   output logic             snap_ack_o,
   output logic [CNT_W-1:0] snap_o,
   output logic             evt_tgl_o
);

   localparam int SW = 4;

   logic [SW-1:0] sync_d, sync_q;
   logic          run_s, autoclr_s, clr_s, snap_req_s;

   assign sync_d = {ctrl_i.autoclr, ctrl_i.run, clr_tgl_i, snap_req_i};

   tmr_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_in_sync (
      .clk   (tclk),
      .rst_n (rst_n),
      .d     (sync_d),
      .q     (sync_q)
   );

   assign {autoclr_s, run_s, clr_s, snap_req_s} = sync_q;

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             clr_ack_q, evt_q, snap_ack_q;
   logic [CNT_W-1:0] snap_q;
   logic             clr_seen, take, tick, at_match;

   assign clr_seen = clr_s != clr_ack_q;
   assign take     = snap_req_s != snap_ack_q;
   assign at_match = cnt_q == match_i;

   // Prescaler variant chosen at elaboration
   if (HAS_PRESCALE) begin : g_pre
      logic [DIV_W-1:0] pre_q;
      always_ff @(posedge tclk or negedge rst_n) begin
         if (!rst_n)        pre_q <= '0;
         else if (clr_seen) pre_q <= '0;
         else if (run_s)    pre_q <= (pre_q >= div_i) ? '0 : pre_q + 1'b1;
      end
      assign tick = run_s && !clr_seen && (pre_q >= div_i);
   end else begin : g_nopre
      logic unused_div;
      assign unused_div = ^div_i;
      assign tick = run_s && !clr_seen;
   end

   assign cnt_nxt = (autoclr_s && at_match) ? '0 : cnt_q + 1'b1;

   always_ff @(posedge tclk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         clr_ack_q <= 1'b0;
         evt_q     <= 1'b0;
      end else if (clr_seen) begin
         cnt_q     <= '0;
         clr_ack_q <= clr_s;
      end else if (tick) begin
         cnt_q <= cnt_nxt;
         if (cnt_nxt == match_i) evt_q <= ~evt_q;
      end
   end

   // Snapshot capture: data held until the next request toggle arrives
   always_ff @(posedge tclk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q     <= '0;
         snap_ack_q <= 1'b0;
      end else if (take) begin
         snap_q     <= cnt_q;
         snap_ack_q <= snap_req_s;
      end
   end

   assign clr_ack_o  = clr_ack_q;
   assign snap_ack_o = snap_ack_q;
   assign snap_o     = snap_q;
   assign evt_tgl_o  = evt_q;

   AST_CLEAR_ZEROES: assert property (@(posedge tclk) disable iff (!rst_n)
      clr_seen |=> cnt_q == '0);                                          // R6
   AST_HOLD_WHEN_OFF: assert property (@(posedge tclk) disable iff (!rst_n)
      (!run_s && !clr_seen) |=> $stable(cnt_q));                          // R4
   AST_STEP_ONE: assert property (@(posedge tclk) disable iff (!rst_n)
      (tick && !(autoclr_s && at_match)) |=> cnt_q == $past(cnt_q) + 1'b1); // R3
   AST_AUTOCLR_WRAP: assert property (@(posedge tclk) disable iff (!rst_n)
      (tick && autoclr_s && at_match) |=> cnt_q == '0);                   // R9
   AST_SNAP_HELD: assert property (@(posedge tclk) disable iff (!rst_n)
      !take |=> $stable(snap_q));                                         // R3

endmodule

// File: rtl/tmr_snap_bus.sv
module tmr_snap_bus #(
   parameter int CNT_W = 32
) (
   input  logic             bclk,
   input  logic             rst_n,
   input  logic             ack_s_i,    // synchronized snapshot acknowledge
   input  logic [CNT_W-1:0] snap_i,     // held stable by the timer domain
   output logic             req_o,
   output logic [CNT_W-1:0] count_o
);

   logic             req_q;
   logic [CNT_W-1:0] count_q;
   logic             done;

   assign done = ack_s_i == req_q;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         count_q <= '0;
      end else if (done) begin
         count_q <= snap_i;
         req_q   <= ~req_q;
      end
   end

   assign req_o   = req_q;
   assign count_o = count_q;

   AST_COUNT_ONLY_ON_DONE: assert property (@(posedge bclk) disable iff (!rst_n)
      !done |=> $stable(count_q));                                        // R3

endmodule

// File: rtl/tmr_bus_regs.sv
module tmr_bus_regs
   import tmr_pkg::*;
#(
   parameter int BUS_W = 32,
   parameter int CNT_W = 32,
   parameter int DIV_W = 2
) (
   input  logic             bclk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [4:0]       addr_i,
   input  logic [BUS_W-1:0] wdata_i,
   output logic [BUS_W-1:0] rdata_o,
   output logic [CNT_W-1:0] match_o,
   output ctrl_t            ctrl_o,
   output logic [DIV_W-1:0] div_o,
   output logic             clr_tgl_o,
   input  logic             clr_ack_s_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             evt_s_i,
   output logic             irq_o
);

   logic [CNT_W-1:0] match_q;
   ctrl_t            ctrl_q;
   logic [DIV_W-1:0] div_q;
   logic             clr_tgl_q, pend;
   logic             evt_d_q, irq_q;
   logic             unused_wdata;

   assign unused_wdata = ^wdata_i;
   assign pend         = clr_tgl_q != clr_ack_s_i;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         match_q   <= '0;
         ctrl_q    <= '0;
         div_q     <= '0;
         clr_tgl_q <= 1'b0;
      end else if (wr_i) begin
         case (addr_i)
            ADR_MATCH: match_q <= wdata_i[CNT_W-1:0];
            ADR_CTRL:  ctrl_q  <= ctrl_t'(wdata_i[1:0]);
            ADR_DIV:   div_q   <= wdata_i[DIV_W-1:0];
            ADR_CLEAR: if (!pend) clr_tgl_q <= ~clr_tgl_q;
            default:   ;
         endcase
      end
   end

   // Match event toggle -> single-cycle pulse
   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         evt_d_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         evt_d_q <= evt_s_i;
         irq_q   <= evt_s_i ^ evt_d_q;
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         ADR_MATCH:  rdata_o = BUS_W'(match_q);
         ADR_COUNT:  rdata_o = BUS_W'(count_i);
         ADR_CTRL:   rdata_o = BUS_W'(ctrl_q);
         ADR_DIV:    rdata_o = BUS_W'(div_q);
         ADR_STATUS: rdata_o = BUS_W'(pend) << STATUS_PEND_BIT;
         default:    rdata_o = '0;
      endcase
   end

   assign match_o   = match_q;
   assign ctrl_o    = ctrl_q;
   assign div_o     = div_q;
   assign clr_tgl_o = clr_tgl_q;
   assign irq_o     = irq_q;

   AST_PEND_SET: assert property (@(posedge bclk) disable iff (!rst_n)
      (wr_i && addr_i == ADR_CLEAR && !pend) |=> pend);                   // R7
   AST_CTRL_HOLD: assert property (@(posedge bclk) disable iff (!rst_n)
      !(wr_i && addr_i == ADR_CTRL) |=> $stable(ctrl_q));                 // R6
   AST_MATCH_HOLD: assert property (@(posedge bclk) disable iff (!rst_n)
      !(wr_i && addr_i == ADR_MATCH) |=> $stable(match_q));               // R2

endmodule

// File: rtl/tmr_match_timer.sv
module tmr_match_timer #(
   parameter int BUS_W        = 32,
   parameter int CNT_W        = 32,
   parameter int DIV_W        = 2,
   parameter int SYNC_STAGES  = 2,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic             bus_clk,
   input  logic             tmr_clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [4:0]       bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             irq
);
   import tmr_pkg::*;

   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("tmr_match_timer: CNT_W must be 2..BUS_W");
   end
   if (BUS_W <= STATUS_PEND_BIT) begin : g_bad_bus
      $error("tmr_match_timer: BUS_W too narrow for status bit");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("tmr_match_timer: DIV_W must be 1..8");
   end

   logic [CNT_W-1:0] match_w, snap_w, count_w;
   ctrl_t            ctrl_w;
   logic [DIV_W-1:0] div_w;
   logic             clr_tgl_w, clr_ack_w, snap_req_w, snap_ack_w, evt_w;
   logic [2:0]       back_d, back_q;
   logic             clr_ack_s, snap_ack_s, evt_s;

   tmr_bus_regs #(.BUS_W(BUS_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
      .bclk        (bus_clk),
      .rst_n       (rst_n),
      .wr_i        (bus_wr),
      .addr_i      (bus_addr),
      .wdata_i     (bus_wdata),
      .rdata_o     (bus_rdata),
      .match_o     (match_w),
      .ctrl_o      (ctrl_w),
      .div_o       (div_w),
      .clr_tgl_o   (clr_tgl_w),
      .clr_ack_s_i (clr_ack_s),
      .count_i     (count_w),
      .evt_s_i     (evt_s),
      .irq_o       (irq)
   );

   tmr_snap_bus #(.CNT_W(CNT_W)) u_snap (
      .bclk    (bus_clk),
      .rst_n   (rst_n),
      .ack_s_i (snap_ack_s),
      .snap_i  (snap_w),
      .req_o   (snap_req_w),
      .count_o (count_w)
   );

   assign back_d = {clr_ack_w, snap_ack_w, evt_w};

   tmr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_back_sync (
      .clk   (bus_clk),
      .rst_n (rst_n),
      .d     (back_d),
      .q     (back_q)
   );

   assign {clr_ack_s, snap_ack_s, evt_s} = back_q;

   tmr_count_core #(
      .CNT_W(CNT_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES), .HAS_PRESCALE(HAS_PRESCALE)
   ) u_core (
      .tclk       (tmr_clk),
      .rst_n      (rst_n),
      .ctrl_i     (ctrl_w),
      .div_i      (div_w),
      .match_i    (match_w),
      .clr_tgl_i  (clr_tgl_w),
      .clr_ack_o  (clr_ack_w),
      .snap_req_i (snap_req_w),
      .snap_ack_o (snap_ack_w),
      .snap_o     (snap_w),
      .evt_tgl_o  (evt_w)
   );

endmodule

// File: tb/tmr_match_timer_bench.sv
module tmr_match_timer_bench;

   logic        bus_clk = 1'b0;
   logic        tmr_clk = 1'b0;
   logic        rst_n   = 1'b0;
   logic        bus_wr  = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   tmr_match_timer u_tmr_match_timer (
      .bus_clk, .tmr_clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .irq
   );

   initial forever #4 bus_clk = ~bus_clk;          // 125 MHz
   initial begin #3; forever #20 tmr_clk = ~tmr_clk; end  // 25 MHz, offset

   int n_chk = 0, n_fail = 0;
   int irq_cnt = 0, irq_run = 0, irq_max = 0;

   typedef struct {
      logic [4:0]  addr;
      logic [31:0] lo;
      logic [31:0] hi;
      string       tag;
   } item_t;
   item_t sbq[$];
   logic  rd_go = 1'b0;

   // Monitor: pops the expected item and compares mid-cycle
   always @(negedge bus_clk) begin
      if (rd_go && sbq.size() > 0) begin
         item_t it;
         it = sbq.pop_front();
         n_chk++;
         if (bus_rdata < it.lo || bus_rdata > it.hi) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h..%h",
                     it.tag, it.addr, bus_rdata, it.lo, it.hi);
         end
         rd_go = 1'b0;
      end
   end

   always @(negedge bus_clk) begin
      if (rst_n && irq) begin
         irq_cnt++; irq_run++;
         if (irq_run > irq_max) irq_max = irq_run;
      end else irq_run = 0;
   end

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(posedge bus_clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge bus_clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [4:0] a, input logic [31:0] lo,
                         input logic [31:0] hi, input string tag);
      item_t it;
      @(posedge bus_clk); #1;
      bus_addr = a;
      it.addr = a; it.lo = lo; it.hi = hi; it.tag = tag;
      sbq.push_back(it);
      rd_go = 1'b1;
      wait (rd_go == 1'b0);
   endtask

   task automatic peek(input logic [4:0] a, output logic [31:0] v);
      @(posedge bus_clk); #1;
      bus_addr = a;
      @(negedge bus_clk);
      v = bus_rdata;
   endtask

   task automatic chk(input string tag, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic bus_wait(input int n);
      repeat (n) @(posedge bus_clk);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] v1, v2;
      bus_wait(10);
      rst_n = 1'b1;
      bus_wait(20);

      // R1: reset values
      rd_chk(5'h00, 0, 0, "R1 match");
      rd_chk(5'h04, 0, 0, "R1 count");
      rd_chk(5'h08, 0, 0, "R1 ctrl");
      rd_chk(5'h10, 0, 0, "R1 div");
      rd_chk(5'h14, 0, 0, "R1 status");
      chk("R1 irq idle", irq_cnt, 0, 0);

      // R2: read-back and field widths, read-only registers
      wr(5'h00, 32'h1234_5678);
      rd_chk(5'h00, 32'h1234_5678, 32'h1234_5678, "R2 match");
      wr(5'h08, 32'hFFFF_FFFE);
      rd_chk(5'h08, 2, 2, "R2 ctrl bits");
      wr(5'h08, 0);
      wr(5'h10, 32'hFFFF_FFFF);
      rd_chk(5'h10, 3, 3, "R2 div bits");
      wr(5'h04, 32'h0000_AAAA);
      wr(5'h14, 32'hFFFF_FFFF);
      bus_wait(40);
      rd_chk(5'h04, 0, 0, "R2 count write ignored");
      rd_chk(5'h14, 0, 0, "R2 status write ignored");

      // R3/R5: count over 120 timer cycles per divider code
      irq_cnt = 0;
      for (int code = 0; code < 4; code++) begin
         int exp;
         exp = 120 / (code + 1);
         wr(5'h10, code);
         wr(5'h0C, 0);
         bus_wait(60);
         wr(5'h08, 1);
         bus_wait(600);
         wr(5'h08, 0);
         bus_wait(60);
         rd_chk(5'h04, exp - 1, exp + 1, $sformatf("R5 R3 div code %0d", code));
      end
      chk("R8 no irq when match unreached", irq_cnt, 0, 0);

      // R4: frozen count is stable and nonzero
      peek(5'h04, v1);
      bus_wait(200);
      rd_chk(5'h04, v1, v1, "R4 frozen count stable");
      chk("R4 frozen not cleared", int'(v1), 29, 31);

      // R6/R7: clear while disabled, any data
      wr(5'h0C, 32'hFFFF_FFFF);
      rd_chk(5'h14, 32'h400, 32'h400, "R7 pending after clear");
      bus_wait(60);
      rd_chk(5'h14, 0, 0, "R7 pending dropped");
      rd_chk(5'h04, 0, 0, "R6 clear while disabled");
      rd_chk(5'h08, 0, 0, "R6 ctrl unchanged");
      rd_chk(5'h10, 3, 3, "R6 div unchanged");
      rd_chk(5'h00, 32'h1234_5678, 32'h1234_5678, "R6 match unchanged");

      // R9/R8: auto-reset on match, period 10 ticks
      wr(5'h10, 0);
      wr(5'h00, 9);
      wr(5'h0C, 32'h5A5A_0000);
      bus_wait(60);
      irq_cnt = 0; irq_max = 0;
      wr(5'h08, 3);
      bus_wait(500);
      wr(5'h08, 0);
      bus_wait(60);
      chk("R9 periodic events", irq_cnt, 9, 11);
      chk("R8 pulse width", irq_max, 1, 1);
      rd_chk(5'h04, 0, 9, "R9 count within period");

      // R9/R8: no auto-reset, counter passes match once
      wr(5'h0C, 0);
      bus_wait(60);
      irq_cnt = 0; irq_max = 0;
      wr(5'h08, 1);
      bus_wait(500);
      wr(5'h08, 0);
      bus_wait(60);
      chk("R8 single event", irq_cnt, 1, 1);
      chk("R8 pulse width single", irq_max, 1, 1);
      rd_chk(5'h04, 99, 101, "R9 passes match");

      finish_run();
   end

endmodule